// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block times the strobes of a multiplexed external memory bus from an oscillator-rate clock. A machine cycle lasts a fixed number of oscillator clocks (twelve by default), split into two halves. At the last clock of each cycle the block samples a request from the CPU for the next cycle. The request is one of four kinds: an internal opcode fetch, an external opcode fetch, an external data read or an external data write. The request also says whether a data access is addressed through a 16-bit pointer or through an 8-bit register pointer.

From the sampled request and a phase counter, the block produces the address-latch pulse, the program-store strobe and the read and write strobes. It also produces the drive enable and the address/data select for the low (multiplexed) port, and the address/SFR select for the high port. Two mode inputs are sampled at the same boundary as the request. The first is an ALE-suppress control bit. The second is a strap saying that the part is running from external program memory, and this strap cancels the suppression.

Top module: `bus_strobe_seq`

## Requirements
- R1: A machine cycle is 12 clocks, numbered phase 0 to 11. `mc_last` is high only in phase 11. `req_kind` (0 internal fetch, 1 external fetch, 2 data read, 3 data write), `req_ptr16`, `ale_dis` and `ext_exec` are sampled only on the clock edge that ends phase 11. A change to them at any other time has no effect on the cycle in progress.
- R2: In fetch cycles (kinds 0 and 1) with ALE not suppressed, `ale` is high in phases 0–1 and 6–7. That gives pulses two clocks wide at one-sixth of the clock rate.
- R3: In data cycles (kinds 2 and 3) `ale` is high only in phases 0–1. The second pulse of the cycle is omitted.
- R4: In an external fetch cycle, `psen_n` is low in phases 3–5 and 9–11. In all other cycle kinds `psen_n` stays high for the whole cycle.
- R5: In a data read `rd_n` is low in phases 5–10, in a data write `wr_n` is low in phases 5–10. Each strobe is six clocks wide and starts three clocks after ALE falls. Otherwise both stay high.
- R6: `p0_drv` is high in phases 0–2 and 6–8 of an external fetch, in phases 0–2 of a data read, in all phases of a data write, and never in an internal fetch. `p0_data_sel` (1 = write data, 0 = low address) is high only in phases 3–11 of a data write.
- R7: `p2_addr_sel` (1 = high address byte, 0 = port SFR contents) is high for the whole cycle of an external fetch, and of a data access with `req_ptr16`=1. It is low otherwise, and `req_ptr16` is ignored in fetch cycles.
- R8: With `ale_dis`=1 and `ext_exec`=0, `ale` stays low and `ale_float` stays high through fetch cycles. Data cycles still give the phase 0–1 pulse with `ale_float` low.
- R9: With `ext_exec`=1, `ale_dis` has no effect, and `ale_float` stays low.
- R10: Reset (`rst_n` low, asynchronous) parks the sequencer in phase 11 of an internal fetch. In that state `ale`=0, `ale_float`=0, all strobes are high, `p0_drv`=0 and `mc_last`=1. The first clock after release starts phase 0 of the sampled request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_kind | input | 2 | Next-cycle request kind |
| req_ptr16 | input | 1 | Data access uses the 16-bit pointer |
| ale_dis | input | 1 | ALE-suppress control bit |
| ext_exec | input | 1 | Running from external program memory |
| mc_last | output | 1 | Final clock of the machine cycle |
| ale | output | 1 | Address latch enable |
| ale_float | output | 1 | ALE pin released to its weak pull-up |
| psen_n | output | 1 | Program store enable, active low |
| rd_n | output | 1 | External data read strobe, active low |
| wr_n | output | 1 | External data write strobe, active low |
| p0_drv | output | 1 | Low port output enable |
| p0_data_sel | output | 1 | Low port carries write data instead of address |
| p2_addr_sel | output | 1 | High port carries address instead of SFR |

## Verification
The bench captures every output across all twelve phases of each cycle and compares it bit for bit with a hand-written phase mask. A strobe placed one clock early or late, or one clock too wide or too narrow, therefore shows as a mask mismatch. It also runs a read straight after an external fetch and a fetch straight after a write. A sequencer that keeps the second ALE pulse in data cycles would show up here, as would one that leaves PSEN running there. It checks the suppress/strap combinations, since a design that lets the suppress bit win over the strap would silence ALE while fetching externally. One read cycle has its request switched to a 16-bit write halfway through. A design that samples the request live would then assert WR or switch the high port mid-cycle. A reset in the middle of a write must release WR and the port drive at once.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

   typedef enum logic [1:0] {
      CYC_INT_FETCH = 2'd0,
      CYC_EXT_FETCH = 2'd1,
      CYC_DATA_RD   = 2'd2,
      CYC_DATA_WR   = 2'd3
   } cyc_kind_t;

   typedef struct packed {
      cyc_kind_t kind;
      logic      ptr16;
      logic      ale_dis;
      logic      ext_exec;
   } cyc_cfg_t;

   localparam cyc_cfg_t CYC_RESET = '{kind: CYC_INT_FETCH, ptr16: 1'b0,
                                      ale_dis: 1'b0, ext_exec: 1'b0};

endpackage

// File: rtl/bus_seq_phase.sv
module bus_seq_phase #(
   parameter int PHASES = 12,
   localparam int PW = $clog2(PHASES)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [PW-1:0] phase,
   output logic          last
);
   localparam logic [PW-1:0] LAST_P = PW'(PHASES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          phase <= LAST_P;
      else if (phase == LAST_P) phase <= '0;
      else                 phase <= phase + 1'b1;
   end

   assign last = (phase == LAST_P);

   AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (phase == '0)); // R1

endmodule

// File: rtl/bus_seq_cyc_latch.sv
module bus_seq_cyc_latch
   import bus_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      last,
   input  cyc_cfg_t  req,
   output cyc_cfg_t  cur
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cur <= CYC_RESET;
      else if (last) cur <= req;
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !last |=> $stable(cur)); // R1

endmodule

// File: rtl/bus_seq_decode.sv
module bus_seq_decode
   import bus_seq_pkg::*;
#(
   parameter int PHASES      = 12,
   parameter int ALE_W       = 2,
   parameter int PSEN_GAP    = 1,
   parameter int PSEN_W      = 3,
   parameter int RD_GAP      = 3,
   parameter int RD_W        = 6,
   parameter bit ALE_GATE_EN = 1'b1,
   localparam int PW = $clog2(PHASES)
) (
   input  logic [PW-1:0] phase,
   input  cyc_cfg_t      cur,
   output logic          ale,
   output logic          ale_float,
   output logic          psen_act,
   output logic          rd_act,
   output logic          wr_act,
   output logic          p0_drv,
   output logic          p0_data_sel,
   output logic          p2_addr_sel
);
   localparam int HALF      = PHASES / 2;
   localparam int ADDR_HOLD = ALE_W + 1;
   localparam int PSEN_ON   = ALE_W + PSEN_GAP;
   localparam int PSEN_OFF  = PSEN_ON + PSEN_W;
   localparam int RD_ON     = ALE_W + RD_GAP;
   localparam int RD_OFF    = RD_ON + RD_W;

   localparam logic [PW-1:0] HALF_P  = PW'(HALF);
   localparam logic [PW-1:0] ALEW_P  = PW'(ALE_W);
   localparam logic [PW-1:0] HOLD_P  = PW'(ADDR_HOLD);
   localparam logic [PW-1:0] PSON_P  = PW'(PSEN_ON);
   localparam logic [PW-1:0] PSOFF_P = PW'(PSEN_OFF);
   localparam logic [PW-1:0] RDON_P  = PW'(RD_ON);
   localparam logic [PW-1:0] RDOFF_P = PW'(RD_OFF);

   logic          second;
   logic [PW-1:0] hp;
   logic          is_data, is_ext, ale_slot, gate_off;

   assign second  = (phase >= HALF_P);
   assign hp      = second ? (phase - HALF_P) : phase;
   assign is_data = cur.kind inside {CYC_DATA_RD, CYC_DATA_WR};
   assign is_ext  = (cur.kind == CYC_EXT_FETCH);

   generate
      if (ALE_GATE_EN) begin : g_ale_gate
         assign gate_off = cur.ale_dis && !cur.ext_exec && !is_data;
      end else begin : g_ale_free
         assign gate_off = 1'b0;
      end
   endgenerate

   assign ale_slot  = (hp < ALEW_P) && !(is_data && second);
   assign ale       = ale_slot && !gate_off;
   assign ale_float = gate_off;

   assign psen_act = is_ext && (hp >= PSON_P) && (hp < PSOFF_P);

   always_comb begin
      rd_act      = 1'b0;
      wr_act      = 1'b0;
      p0_drv      = 1'b0;
      p0_data_sel = 1'b0;
      p2_addr_sel = 1'b0;
      unique case (cur.kind)
         CYC_INT_FETCH: ;
         CYC_EXT_FETCH: begin
            p0_drv      = (hp < HOLD_P);
            p2_addr_sel = 1'b1;
         end
         CYC_DATA_RD: begin
            rd_act      = (phase >= RDON_P) && (phase < RDOFF_P);
            p0_drv      = (phase < HOLD_P);
            p2_addr_sel = cur.ptr16;
         end
         CYC_DATA_WR: begin
            wr_act      = (phase >= RDON_P) && (phase < RDOFF_P);
            p0_drv      = 1'b1;
            p0_data_sel = (phase >= HOLD_P);
            p2_addr_sel = cur.ptr16;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
   import bus_seq_pkg::*;
#(
   parameter int PHASES      = 12,
   parameter int ALE_W       = 2,
   parameter int PSEN_GAP    = 1,
   parameter int PSEN_W      = 3,
   parameter int RD_GAP      = 3,
   parameter int RD_W        = 6,
   parameter bit ALE_GATE_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] req_kind,
   input  logic       req_ptr16,
   input  logic       ale_dis,
   input  logic       ext_exec,
   output logic       mc_last,
   output logic       ale,
   output logic       ale_float,
   output logic       psen_n,
   output logic       rd_n,
   output logic       wr_n,
   output logic       p0_drv,
   output logic       p0_data_sel,
   output logic       p2_addr_sel
);
   localparam int PW   = $clog2(PHASES);
   localparam int HALF = PHASES / 2;

   initial begin
      assert (PHASES % 2 == 0) else $error("phase count must be even");
      assert (ALE_W + PSEN_GAP + PSEN_W <= HALF) else $error("PSEN window overruns half cycle");
      assert (ALE_W + RD_GAP + RD_W <= PHASES - 1) else $error("RD/WR window overruns cycle");
      assert (PSEN_GAP >= 1 && RD_GAP >= 1) else $error("strobe must trail ALE");
   end

   logic [PW-1:0] phase;
   cyc_cfg_t      req, cur;
   logic          psen_act, rd_act, wr_act;

   assign req = '{kind: cyc_kind_t'(req_kind), ptr16: req_ptr16,
                  ale_dis: ale_dis, ext_exec: ext_exec};

   bus_seq_phase #(.PHASES(PHASES)) phase_i (
      .clk(clk), .rst_n(rst_n), .phase(phase), .last(mc_last));

   bus_seq_cyc_latch latch_i (
      .clk(clk), .rst_n(rst_n), .last(mc_last), .req(req), .cur(cur));

   bus_seq_decode #(
      .PHASES(PHASES), .ALE_W(ALE_W), .PSEN_GAP(PSEN_GAP), .PSEN_W(PSEN_W),
      .RD_GAP(RD_GAP), .RD_W(RD_W), .ALE_GATE_EN(ALE_GATE_EN)
   ) decode_i (
      .phase(phase), .cur(cur), .ale(ale), .ale_float(ale_float),
      .psen_act(psen_act), .rd_act(rd_act), .wr_act(wr_act),
      .p0_drv(p0_drv), .p0_data_sel(p0_data_sel), .p2_addr_sel(p2_addr_sel));

   assign psen_n = !psen_act;
   assign rd_n   = !rd_act;
   assign wr_n   = !wr_act;

   AST_ALE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale) |=> ale); // R2
   AST_NO_PSEN_DURING_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |-> (psen_n && !ale)); // R4
   AST_RD_TRAILS_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |-> ($past(ale, 4) && !$past(ale, 3))); // R5
   AST_WR_DRIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> (p0_drv && p0_data_sel)); // R6
   AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ale_float |-> !ale); // R8

endmodule

// File: tb/bus_strobe_seq_tb.sv
module bus_strobe_seq_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] req_kind = 2'd0;
   logic       req_ptr16 = 1'b0, ale_dis = 1'b0, ext_exec = 1'b0;
   logic       mc_last, ale, ale_float, psen_n, rd_n, wr_n;
   logic       p0_drv, p0_data_sel, p2_addr_sel;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   bus_strobe_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .req_ptr16(req_ptr16),
      .ale_dis(ale_dis), .ext_exec(ext_exec), .mc_last(mc_last), .ale(ale),
      .ale_float(ale_float), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
      .p0_drv(p0_drv), .p0_data_sel(p0_data_sel), .p2_addr_sel(p2_addr_sel));

   // {kind, ptr16, dis, ext, ale, float, psen_act, rd_act, wr_act, p0_drv, data_sel, p2}
   // masks: bit i = phase i
   localparam int NV = 12;
   localparam logic [100:0] VEC [NV] = '{
      {2'd0,1'b0,1'b0,1'b0,12'h0C3,12'h000,12'h000,12'h000,12'h000,12'h000,12'h000,12'h000},
      {2'd1,1'b0,1'b0,1'b1,12'h0C3,12'h000,12'hE38,12'h000,12'h000,12'h1C7,12'h000,12'hFFF},
      {2'd2,1'b1,1'b0,1'b1,12'h003,12'h000,12'h000,12'h7E0,12'h000,12'h007,12'h000,12'hFFF},
      {2'd3,1'b0,1'b0,1'b0,12'h003,12'h000,12'h000,12'h000,12'h7E0,12'hFFF,12'hFF8,12'h000},
      {2'd0,1'b0,1'b1,1'b0,12'h000,12'hFFF,12'h000,12'h000,12'h000,12'h000,12'h000,12'h000},
      {2'd2,1'b0,1'b1,1'b0,12'h003,12'h000,12'h000,12'h7E0,12'h000,12'h007,12'h000,12'h000},
      {2'd1,1'b0,1'b1,1'b1,12'h0C3,12'h000,12'hE38,12'h000,12'h000,12'h1C7,12'h000,12'hFFF},
      {2'd3,1'b1,1'b1,1'b1,12'h003,12'h000,12'h000,12'h000,12'h7E0,12'hFFF,12'hFF8,12'hFFF},
      {2'd0,1'b1,1'b0,1'b0,12'h0C3,12'h000,12'h000,12'h000,12'h000,12'h000,12'h000,12'h000},
      {2'd2,1'b0,1'b0,1'b0,12'h003,12'h000,12'h000,12'h7E0,12'h000,12'h007,12'h000,12'h000},
      {2'd1,1'b0,1'b0,1'b1,12'h0C3,12'h000,12'hE38,12'h000,12'h000,12'h1C7,12'h000,12'hFFF},
      {2'd0,1'b0,1'b1,1'b1,12'h0C3,12'h000,12'h000,12'h000,12'h000,12'h000,12'h000,12'h000}
   };
   // 16-bit-pointer write, sampled after a mid-cycle request change
   localparam logic [100:0] WR16 =
      {2'd3,1'b1,1'b0,1'b0,12'h003,12'h000,12'h000,12'h000,12'h7E0,12'hFFF,12'hFF8,12'hFFF};

   task automatic chk(input string tag, input string what, input logic [11:0] got,
                      input logic [11:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("  FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic set_in(input logic [100:0] v);
      req_kind  = v[100:99];
      req_ptr16 = v[98];
      ale_dis   = v[97];
      ext_exec  = v[96];
   endtask

   // called at the negedge of phase 11 (or of reset release); returns at the next phase 11 negedge
   task automatic run_cycle(input logic [100:0] v, input int flip_at);
      logic [11:0] s_ale, s_flt, s_ps, s_rd, s_wr, s_p0, s_ds, s_p2, s_last;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         s_ale[i] = ale;        s_flt[i] = ale_float;
         s_ps[i]  = !psen_n;    s_rd[i]  = !rd_n;      s_wr[i] = !wr_n;
         s_p0[i]  = p0_drv;     s_ds[i]  = p0_data_sel; s_p2[i] = p2_addr_sel;
         s_last[i] = mc_last;
         if (i == flip_at) begin   // R1: mid-cycle request change must be ignored
            req_kind = 2'd3; req_ptr16 = 1'b1;
         end
      end
      chk("R1",    "mc_last",     s_last, 12'h800);
      chk("R2,R3", "ale",         s_ale,  v[95:84]);
      chk("R8,R9", "ale_float",   s_flt,  v[83:72]);
      chk("R4",    "psen",        s_ps,   v[71:60]);
      chk("R5",    "rd",          s_rd,   v[59:48]);
      chk("R5",    "wr",          s_wr,   v[47:36]);
      chk("R6",    "p0_drv",      s_p0,   v[35:24]);
      chk("R6",    "p0_data_sel", s_ds,   v[23:12]);
      chk("R7",    "p2_addr_sel", s_p2,   v[11:0]);
   endtask

   task automatic chk_parked(input string when);
      chk("R10", {when, " ale"},    {11'd0, ale},       12'h000);
      chk("R10", {when, " float"},  {11'd0, ale_float}, 12'h000);
      chk("R10", {when, " strobes"}, {9'd0, psen_n, rd_n, wr_n}, 12'h007);
      chk("R10", {when, " p0_drv"}, {11'd0, p0_drv},    12'h000);
      chk("R10", {when, " mc_last"}, {11'd0, mc_last},  12'h001);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("  FAIL R1 watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R10: state held in reset
      set_in(VEC[0]);
      repeat (3) @(negedge clk);
      chk_parked("in reset");
      rst_n = 1'b1;

      // table walk: each row sets next-cycle inputs, then checks every phase
      for (int k = 0; k < NV; k++) begin
         set_in(VEC[k]);
         run_cycle(VEC[k], -1);
      end

      // R1: request switched to a 16-bit write at phase 5 of an 8-bit read
      set_in(VEC[9]);
      run_cycle(VEC[9], 5);
      run_cycle(WR16, -1);   // the switched request takes effect only now

      // R10: asynchronous reset in the middle of a write
      set_in(VEC[3]);
      repeat (6) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk_parked("mid-write reset");
      set_in(VEC[1]);
      @(negedge clk);
      rst_n = 1'b1;
      run_cycle(VEC[1], -1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule